// File: doc/BRIEF.md
# Sampling Converter Capture Controller

This block sits between a system-clock domain and an 8-bit converter with parallel outputs. The converter has a pipeline and samples on the falling edge of its clock. The controller makes the converter clock by counting system clocks, so one half-period of the converter clock lasts a programmable number of system cycles. It also drives the converter's active-low output enable, and it captures the returned bytes on falling edges. Each byte is tagged with the index of the sample it represents. The converter's result for a sample appears two and a half clock periods after the falling edge that took that sample. Captures happen on falling edges, so the word captured at falling edge `j` belongs to sample `j-3`.

Software starts and stops conversion with a level input. When conversion is stopped, the converter clock is parked low, never high. After reset the controller always gives the converter two full clock periods and then parks the clock, even if no conversion has been requested. Each time conversion restarts from the parked state, the first three captured words are dropped. A divider setting that would put the converter clock outside its legal frequency window is refused. Captured words leave the block through a valid/ready stream. If the consumer falls behind, the converter clock keeps running and a sticky overflow flag is raised.

Top module: `adc_capture_ctrl`

## Requirements
- R1: A synchronous reset drives `conv_clk` low and `conv_oe_n` high. It clears `out_valid` and `overflow`, and it clears the sample index, so the first converter falling edge after reset is sample 0.
- R2: After reset, with `run` low, `conv_clk` makes exactly two full periods (two rising and two falling edges) and then stays low. `conv_oe_n` stays high during this time.
- R3: Each half-period of `conv_clk` lasts `div` system cycles. With `SYS_MHZ`=100, `FMIN_MHZ`=1 and `FMAX_MHZ`=30, the values 2 to 50 are accepted. A `cfg_load` with any other value leaves the active divider unchanged and sets `cfg_err` to 1 on the next cycle. A load with an accepted value sets `cfg_err` to 0.
- R4: Captures are taken on falling edges of `conv_clk`. The word captured at falling edge `j` (counted from 0 since reset) is output with `out_tag` = `j-3`.
- R5: Each time conversion starts from the parked state, the first three captures are dropped. The first word output therefore has a tag equal to the index of the run's first falling edge.
- R6: `conv_oe_n` goes low at least one full `conv_clk` period (2·`div` system cycles) before the first falling edge of a run. A capture made while `conv_oe_n` is high is never output.
- R7: After `run` is deasserted, `conv_clk` finishes any high phase and then stops low. `conv_oe_n` returns high only when the clock is parked low. Once parked, `conv_clk` makes no further edges.
- R8: `out_valid` stays high until `out_ready` is sampled high. While the stream is stalled, `out_tag` and `out_data` do not change unless they are overwritten under R9.
- R9: If a new capture arrives while a word is still waiting for `out_ready`, the new word replaces the old one, `overflow` rises and stays high until reset, and `conv_clk` keeps toggling.
- R10: `out_data` is the converter byte unchanged, in straight binary: the saturated codes 0x00 and 0xFF pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Level request to convert |
| cfg_load | input | 1 | Pulse that offers `cfg_div` as the new half-period |
| cfg_div | input | DIV_W | Requested half-period in system cycles |
| cfg_err | output | 1 | 1 when the last offered divider was refused |
| conv_clk | output | 1 | Clock to the converter |
| conv_oe_n | output | 1 | Converter output enable, active low |
| conv_data | input | 8 | Data bus from the converter |
| out_valid | output | 1 | Stream word available |
| out_ready | input | 1 | Consumer accepts the word |
| out_data | output | 8 | Captured converter code |
| out_tag | output | 16 | Sample index of `out_data` |
| overflow | output | 1 | Sticky flag: a stream word was lost |

## Verification
The bound checker watches on every cycle that the clock is parked only in its low phase, that no converter half-period is shorter than the legal minimum, and that a refused divider raises the error flag. It also checks that a word becomes valid only after the output enable was already low, that a stalled word is held, and that overflow stays set once raised. The testbench scenarios are the only check on the sample alignment. A converter model with the same pipeline quantises a known input ramp, and each output tag and code is compared with the bench's own arithmetic. The scenarios also show the two-period power-up burst, the three dropped words after each restart, the measured half-period for several dividers, and the lead time of the enable.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;

    localparam int unsigned DATA_W = 8;
    localparam int unsigned TAG_W  = 16;

    typedef enum logic [1:0] {
        SEQ_BOOT = 2'd0,
        SEQ_PARK = 2'd1,
        SEQ_RUN  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] data;
    } cap_word_t;

    // smallest half-period that keeps the converter clock at or below fmax
    function automatic int unsigned div_floor(input int unsigned sys_mhz,
                                              input int unsigned fmax_mhz);
        return (sys_mhz + 2 * fmax_mhz - 1) / (2 * fmax_mhz);
    endfunction

    // largest half-period that keeps the converter clock at or above fmin
    function automatic int unsigned div_ceil(input int unsigned sys_mhz,
                                             input int unsigned fmin_mhz);
        return sys_mhz / (2 * fmin_mhz);
    endfunction

    function automatic logic div_legal(input int unsigned d,
                                       input int unsigned lo,
                                       input int unsigned hi);
        return (d >= lo) && (d <= hi);
    endfunction

endpackage

// File: rtl/adc_clk_gen.sv
module adc_clk_gen #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clk_en,
    input  logic [DIV_W-1:0] div,
    output logic             conv_clk,
    output logic             fall_ev
);
    logic [DIV_W-1:0] cnt;
    logic             tick;

    assign tick    = (cnt >= div - DIV_W'(1));
    // a high phase always runs to completion, so the clock can only park low
    assign fall_ev = conv_clk && tick;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            conv_clk <= 1'b0;
        end else if (!clk_en && !conv_clk) begin
            cnt <= '0;
        end else if (tick) begin
            cnt      <= '0;
            conv_clk <= ~conv_clk;
        end else begin
            cnt <= cnt + DIV_W'(1);
        end
    end
endmodule

// File: rtl/adc_seq.sv
module adc_seq
    import adc_cap_pkg::*;
#(
    parameter int unsigned BOOT_CYC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic fall_ev,
    input  logic conv_clk,
    output logic clk_en,
    output logic oe_n,
    output logic arm
);
    localparam int unsigned BC_W = $clog2(BOOT_CYC + 1);

    seq_state_e      state;
    logic [BC_W-1:0] boot_cnt;

    assign clk_en = (state == SEQ_BOOT) || ((state == SEQ_RUN) && run);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SEQ_BOOT;
            boot_cnt <= '0;
            oe_n     <= 1'b1;
            arm      <= 1'b0;
        end else begin
            arm <= 1'b0;
            unique case (state)
                SEQ_BOOT: begin
                    if (fall_ev) begin
                        if (boot_cnt == BC_W'(BOOT_CYC - 1)) state <= SEQ_PARK;
                        else boot_cnt <= boot_cnt + BC_W'(1);
                    end
                end
                SEQ_PARK: begin
                    if (run) begin
                        state <= SEQ_RUN;
                        oe_n  <= 1'b0;
                        arm   <= 1'b1;
                    end
                end
                SEQ_RUN: begin
                    if (!run && !conv_clk) begin
                        state <= SEQ_PARK;
                        oe_n  <= 1'b1;
                    end
                end
                default: state <= SEQ_PARK;
            endcase
        end
    end
endmodule

// File: rtl/adc_lat_tag.sv
module adc_lat_tag
    import adc_cap_pkg::*;
#(
    parameter int unsigned LAT_FALLS = 3,
    parameter int unsigned DISCARD   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fall_ev,
    input  logic              arm,
    input  logic              oe_n,
    input  logic [DATA_W-1:0] bus,
    input  logic              out_ready,
    output logic              out_valid,
    output cap_word_t         out_word,
    output logic              overflow
);
    localparam int unsigned DISC_W = $clog2(DISCARD + 2);

    logic [TAG_W-1:0]  fall_cnt;
    logic [DISC_W-1:0] disc;
    logic              cap_ok;

    assign cap_ok = fall_ev && !oe_n && (disc == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            fall_cnt  <= '0;
            disc      <= DISC_W'(DISCARD);
            out_valid <= 1'b0;
            out_word  <= '0;
            overflow  <= 1'b0;
        end else begin
            if (fall_ev) fall_cnt <= fall_cnt + TAG_W'(1);

            if (arm) disc <= DISC_W'(DISCARD);
            else if (fall_ev && !oe_n && (disc != '0)) disc <= disc - DISC_W'(1);

            if (cap_ok) begin
                out_valid <= 1'b1;
                out_word  <= '{tag: fall_cnt - TAG_W'(LAT_FALLS), data: bus};
                if (out_valid && !out_ready) overflow <= 1'b1;
            end else if (out_ready) begin
                out_valid <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/adc_capture_ctrl.sv
module adc_capture_ctrl
    import adc_cap_pkg::*;
#(
    parameter int unsigned DIV_W     = 8,
    parameter int unsigned SYS_MHZ   = 100,
    parameter int unsigned FMIN_MHZ  = 1,
    parameter int unsigned FMAX_MHZ  = 30,
    parameter int unsigned BOOT_CYC  = 2,
    parameter int unsigned LAT_FALLS = 3,
    parameter int unsigned DISCARD   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              cfg_load,
    input  logic [DIV_W-1:0]  cfg_div,
    output logic              cfg_err,
    output logic              conv_clk,
    output logic              conv_oe_n,
    input  logic [DATA_W-1:0] conv_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic [TAG_W-1:0]  out_tag,
    output logic              overflow
);
    localparam int unsigned DIV_LO = div_floor(SYS_MHZ, FMAX_MHZ);
    localparam int unsigned DIV_HI = div_ceil(SYS_MHZ, FMIN_MHZ);

    logic [DIV_W-1:0] div_q;
    logic             clk_en, fall_ev, arm;
    cap_word_t        word;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q   <= DIV_W'(DIV_LO);
            cfg_err <= 1'b0;
        end else if (cfg_load) begin
            if (div_legal(32'(cfg_div), DIV_LO, DIV_HI)) begin
                div_q   <= cfg_div;
                cfg_err <= 1'b0;
            end else begin
                cfg_err <= 1'b1;
            end
        end
    end

    adc_clk_gen #(.DIV_W(DIV_W)) u_clk (
        .clk(clk), .rst(rst), .clk_en(clk_en), .div(div_q),
        .conv_clk(conv_clk), .fall_ev(fall_ev)
    );

    adc_seq #(.BOOT_CYC(BOOT_CYC)) u_seq (
        .clk(clk), .rst(rst), .run(run), .fall_ev(fall_ev), .conv_clk(conv_clk),
        .clk_en(clk_en), .oe_n(conv_oe_n), .arm(arm)
    );

    adc_lat_tag #(.LAT_FALLS(LAT_FALLS), .DISCARD(DISCARD)) u_tag (
        .clk(clk), .rst(rst), .fall_ev(fall_ev), .arm(arm), .oe_n(conv_oe_n),
        .bus(conv_data), .out_ready(out_ready), .out_valid(out_valid),
        .out_word(word), .overflow(overflow)
    );

    assign out_data = word.data;
    assign out_tag  = word.tag;
endmodule

// File: rtl/adc_capture_ctrl_chk.sv
module adc_capture_ctrl_chk
    import adc_cap_pkg::*;
#(
    parameter int unsigned DIV_W    = 8,
    parameter int unsigned SYS_MHZ  = 100,
    parameter int unsigned FMIN_MHZ = 1,
    parameter int unsigned FMAX_MHZ = 30
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_load,
    input logic [DIV_W-1:0] cfg_div,
    input logic             cfg_err,
    input logic             conv_clk,
    input logic             conv_oe_n,
    input logic             out_valid,
    input logic             out_ready,
    input logic [TAG_W-1:0] out_tag,
    input logic             overflow
);
    localparam int unsigned LO = div_floor(SYS_MHZ, FMAX_MHZ);
    localparam int unsigned HI = div_ceil(SYS_MHZ, FMIN_MHZ);

    AST_RESET_PARKS: assert property (@(posedge clk)
        rst |=> (!conv_clk && conv_oe_n && !out_valid && !overflow)); // R1

    AST_BAD_DIV_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        (cfg_load && !((32'(cfg_div) >= LO) && (32'(cfg_div) <= HI))) |=> cfg_err); // R3

    generate
        if (LO >= 2) begin : g_min_half
            AST_HALF_PERIOD_MIN: assert property (@(posedge clk) disable iff (rst)
                !$stable(conv_clk) |=> $stable(conv_clk)); // R3
        end
    endgenerate

    AST_OE_LEADS_VALID: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> !$past(conv_oe_n)); // R6

    AST_HALT_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(conv_oe_n) |-> !conv_clk); // R7

    AST_HOLD_UNTIL_READY: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && ($stable(out_tag) || overflow))); // R8

    AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow); // R9
endmodule

bind adc_capture_ctrl adc_capture_ctrl_chk #(
    .DIV_W(DIV_W), .SYS_MHZ(SYS_MHZ), .FMIN_MHZ(FMIN_MHZ), .FMAX_MHZ(FMAX_MHZ)
) u_chk (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_div(cfg_div), .cfg_err(cfg_err),
    .conv_clk(conv_clk), .conv_oe_n(conv_oe_n), .out_valid(out_valid),
    .out_ready(out_ready), .out_tag(out_tag), .overflow(overflow)
);

// File: tb/test_adc_capture_ctrl.sv
module test_adc_capture_ctrl;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run = 1'b0;
    logic        cfg_load = 1'b0;
    logic [7:0]  cfg_div = 8'd0;
    logic        cfg_err, conv_clk, conv_oe_n, out_valid, overflow;
    logic        out_ready = 1'b1;
    logic [7:0]  conv_data, out_data;
    logic [15:0] out_tag;

    int n_chk = 0, n_bad = 0, cyc = 0, rises = 0, nfall = 0;
    int exp_tag = 0, got = 0, first_tag = -1;
    logic mon_on = 1'b0, seen_zero = 1'b0, seen_ff = 1'b0;

    always #(CLK_P/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    adc_capture_ctrl i_adc_capture_ctrl (
        .clk(clk), .rst(rst), .run(run), .cfg_load(cfg_load), .cfg_div(cfg_div),
        .cfg_err(cfg_err), .conv_clk(conv_clk), .conv_oe_n(conv_oe_n),
        .conv_data(conv_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_tag(out_tag), .overflow(overflow)
    );

    // input ramp in millivolts, references at 600 and 2600 mV
    function automatic int volt(input int n);
        return ((n * 53) % 2600) + 100;
    endfunction
    function automatic int quant(input int v);
        if (v <= 600) return 0;
        if (v >= 2600) return 255;
        return ((v - 600) * 256) / 2000;
    endfunction

    // converter model: sample on fall, result driven 2.5 periods later
    logic [7:0] p0 = 0, p1 = 0, p2 = 0, dout = 0;
    always @(negedge conv_clk or posedge rst) begin
        if (rst) nfall <= 0;
        else begin
            p2 <= p1; p1 <= p0; p0 <= 8'(quant(volt(nfall)));
            nfall <= nfall + 1;
        end
    end
    always @(posedge conv_clk) begin
        rises <= rises + 1;
        dout  <= #1 p2;
    end
    assign conv_data = conv_oe_n ? 8'hA5 : dout;

    task automatic chk(input logic ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    always @(negedge clk) begin
        if (mon_on && out_valid && out_ready) begin
            if (first_tag < 0) first_tag = int'(out_tag);
            chk(int'(out_tag) == exp_tag, "R4 tag", int'(out_tag), exp_tag);
            chk(int'(out_data) == quant(volt(int'(out_tag))), "R10 code",
                int'(out_data), quant(volt(int'(out_tag))));
            if (out_data == 8'h00) seen_zero = 1'b1;
            if (out_data == 8'hFF) seen_ff = 1'b1;
            exp_tag = int'(out_tag) + 1;
            got++;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic load_div(input int d);
        cfg_div = 8'(d); cfg_load = 1'b1; tick(1); cfg_load = 1'b0;
    endtask

    task automatic run_burst(input int d, input int bad, input int nout);
        int t0, t1, hi, r, start, guard;
        logic pc;
        load_div(d);
        chk(cfg_err == 1'b0, "R3 accept", int'(cfg_err), 0);
        if (bad >= 0) begin
            load_div(bad);
            chk(cfg_err == 1'b1, "R3 reject", int'(cfg_err), 1);
        end
        start = nfall; first_tag = -1; exp_tag = start; got = 0; mon_on = 1'b1;
        run = 1'b1;
        do @(negedge clk); while (conv_oe_n);
        t0 = cyc;
        do begin pc = conv_clk; @(negedge clk); end while (!(pc && !conv_clk));
        t1 = cyc;
        chk(t1 - t0 >= 2 * d, "R6 enable lead", t1 - t0, 2 * d);
        do begin pc = conv_clk; @(negedge clk); end while (!(!pc && conv_clk));
        hi = 0;
        while (conv_clk) begin hi++; @(negedge clk); end
        chk(hi == d, "R3 half period", hi, d);
        guard = 0;
        while (got < nout && guard < 50000) begin @(negedge clk); guard++; end
        chk(got >= nout, "R4 output count", got, nout);
        chk(first_tag == start, "R5 first tag", first_tag, start);
        tick(1); run = 1'b0;
        tick(2 * d + 4);
        chk(conv_clk == 1'b0, "R7 parked low", int'(conv_clk), 0);
        chk(conv_oe_n == 1'b1, "R7 enable off", int'(conv_oe_n), 1);
        r = rises;
        tick(40);
        chk(rises == r, "R7 no edges", rises, r);
        mon_on = 1'b0;
    endtask

    initial begin
        #(CLK_P * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int r, tg;
        tick(4);
        chk(conv_clk == 1'b0, "R1 clk", int'(conv_clk), 0);
        chk(conv_oe_n == 1'b1, "R1 oe", int'(conv_oe_n), 1);
        chk(out_valid == 1'b0, "R1 valid", int'(out_valid), 0);
        chk(overflow == 1'b0, "R1 ovf", int'(overflow), 0);
        rst = 1'b0;
        tick(60);
        chk(rises == 2, "R2 boot rises", rises, 2);
        chk(nfall == 2, "R2 boot falls", nfall, 2);
        chk(conv_clk == 1'b0, "R2 parked", int'(conv_clk), 0);
        chk(conv_oe_n == 1'b1, "R2 oe off", int'(conv_oe_n), 1);
        chk(out_valid == 1'b0, "R6 no capture with oe high", int'(out_valid), 0);

        for (int v = 0; v < 256; v++) begin
            load_div(v);
            chk(cfg_err == ((v >= 2 && v <= 50) ? 1'b0 : 1'b1), "R3 range",
                int'(cfg_err), (v >= 2 && v <= 50) ? 0 : 1);
        end

        run_burst(3, 1, 30);
        run_burst(2, 51, 30);
        run_burst(4, 0, 25);
        run_burst(7, 200, 20);
        run_burst(50, -1, 8);

        // stall, then overflow
        load_div(2);
        out_ready = 1'b0; r = rises; run = 1'b1;
        do @(negedge clk); while (!out_valid);
        tg = int'(out_tag);
        @(negedge clk);
        chk(out_valid == 1'b1, "R8 held valid", int'(out_valid), 1);
        chk(int'(out_tag) == tg, "R8 held tag", int'(out_tag), tg);
        tick(60);
        chk(overflow == 1'b1, "R9 overflow", int'(overflow), 1);
        chk(rises > r + 10, "R9 clock not stalled", rises, r + 11);
        run = 1'b0; tick(20);
        out_ready = 1'b1; tick(2);
        chk(out_valid == 1'b0, "R8 drained", int'(out_valid), 0);
        chk(overflow == 1'b1, "R9 sticky", int'(overflow), 1);

        // reset while running
        run = 1'b1; tick(30);
        rst = 1'b1; run = 1'b0; tick(3);
        chk(conv_clk == 1'b0, "R1 clk", int'(conv_clk), 0);
        chk(conv_oe_n == 1'b1, "R1 oe", int'(conv_oe_n), 1);
        chk(out_valid == 1'b0, "R1 valid", int'(out_valid), 0);
        chk(overflow == 1'b0, "R1 ovf", int'(overflow), 0);
        rst = 1'b0; tick(40);
        chk(nfall == 2, "R2 boot after reset", nfall, 2);
        run_burst(5, -1, 20);
        chk(seen_zero == 1'b1, "R10 code 0x00", int'(seen_zero), 1);
        chk(seen_ff == 1'b1, "R10 code 0xFF", int'(seen_ff), 1);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule